// File: doc/BRIEF.md
# Interrupt Pending and Mask Register Bank

This block is the register-mapped front end of an interrupt controller with 21 request lines. Every clock it samples the request inputs and latches any asserted line into a sticky pending bit. Software clears a pending bit by writing a 1 to it. A per-source enable mask and a single global mask decide which pending bits may reach the processor. A per-source mode bit sends each source to either the fast interrupt output or the normal interrupt output. A pending-test register lets software load the whole pending vector in one write.

The pending, mask, global mask and mode vectors are also brought out as plain ports. A separate priority resolver reads them from there, and this block does no ordering of its own. Access goes through a simple synchronous bus: a select, a write enable, a byte address and a 32-bit write and read data word. Read data is registered.

Top module: `irq_gate_bank`

## Requirements
- R1: Reset state. The mode register is 0 and the pending register is 0. The mask register is 0x003FFFFF: bits 20:0 are per-source masks, bit 21 is the global mask, and all of them are set. `fiq_o`, `irq_o` and `bus_rdata_o` are 0.
- R2: A request line that is high at a rising edge sets that source's pending bit at that edge. When a request and a write-1 clear hit the same bit in the same cycle, the request wins and the bit stays set.
- R3: A write to offset 0x04 clears every pending bit whose data bit is 1. Data bits of 0 leave the pending bits unchanged.
- R4: A pending, enabled source with mode bit 1 (mode register at offset 0x00) drives `fiq_o`. With mode bit 0 it drives `irq_o` instead. Each output is registered and follows the register state one cycle later.
- R5: A per-source mask bit of 1 (mask register at offset 0x08) keeps that source off both outputs. Its pending bit still latches. Clearing the mask bit releases the held interrupt.
- R6: While mask bit 21 (global) is 1, both outputs stay 0 and pending bits still latch. Clearing bit 21 lets the held pending interrupts reach the outputs.
- R7: A write to offset 0x2C loads bits 20:0 of the data word straight into the pending bits, setting or clearing each one. Reading offset 0x2C returns 0.
- R8: A read at 0x00, 0x04 or 0x08 returns the register in `bus_rdata_o` after the next rising edge. Unused upper bits read as 0. Bit 21 can be written only in the mask register. Unmapped offsets read as 0.
- R9: `pend_o`, `mask_o`, `gmask_o` and `mode_o` always show the current register state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 21 | Interrupt request lines, sampled every clock |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| fiq_o | output | 1 | Fast interrupt request to the processor |
| irq_o | output | 1 | Normal interrupt request to the processor |
| pend_o | output | 21 | Pending vector for the resolver |
| mask_o | output | 21 | Per-source mask vector |
| gmask_o | output | 1 | Global mask bit |
| mode_o | output | 21 | Mode vector (1 = fast) |

## Verification
A request or register write sampled at edge k changes the register state and the export ports at edge k. The registered `fiq_o`/`irq_o` follow at edge k+1. A read sampled at edge k shows in `bus_rdata_o` right after edge k. The driver tasks log each expected output or read value in a queue, tagged with the cycle in which it falls due. The monitor compares each entry on the falling edge of that exact cycle, so results are never sampled early or late. The export vectors are checked directly on the falling edge after the write that changed them.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
   // register selected by the bus decoder
   typedef enum logic [2:0] {
      RSEL_NONE = 3'd0,
      RSEL_MODE = 3'd1,
      RSEL_PEND = 3'd2,
      RSEL_MASK = 3'd3,
      RSEL_TEST = 3'd4
   } rsel_e;
endpackage

// File: rtl/irq_bus_port.sv
module irq_bus_port
   import irq_gate_pkg::*;
#(
   parameter int NUM_SRC  = 21,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int OFS_MODE = 'h00,
   parameter int OFS_PEND = 'h04,
   parameter int OFS_MASK = 'h08,
   parameter int OFS_TEST = 'h2C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_i,
   input  logic               we_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NUM_SRC-1:0] mode_i,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC:0]   mask_i,
   output logic               mode_we_o,
   output logic               pend_we_o,
   output logic               mask_we_o,
   output logic               test_we_o,
   output logic [DATA_W-1:0]  rdata_o
);
   rsel_e             rsel;
   logic [DATA_W-1:0] rdata_n;

   always_comb begin
      if (addr_i == ADDR_W'(OFS_MODE))      rsel = RSEL_MODE;
      else if (addr_i == ADDR_W'(OFS_PEND)) rsel = RSEL_PEND;
      else if (addr_i == ADDR_W'(OFS_MASK)) rsel = RSEL_MASK;
      else if (addr_i == ADDR_W'(OFS_TEST)) rsel = RSEL_TEST;
      else                                  rsel = RSEL_NONE;
   end

   assign mode_we_o = sel_i && we_i && (rsel == RSEL_MODE);
   assign pend_we_o = sel_i && we_i && (rsel == RSEL_PEND);
   assign mask_we_o = sel_i && we_i && (rsel == RSEL_MASK);
   assign test_we_o = sel_i && we_i && (rsel == RSEL_TEST);

   always_comb begin
      rdata_n = '0;
      case (rsel)
         RSEL_MODE: rdata_n[NUM_SRC-1:0] = mode_i;
         RSEL_PEND: rdata_n[NUM_SRC-1:0] = pend_i;
         RSEL_MASK: rdata_n[NUM_SRC:0]   = mask_i;
         default:   rdata_n = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rdata_o <= '0;
      else if (sel_i && !we_i) rdata_o <= rdata_n;
   end

   // read of the pending register returns the state seen in the read cycle
   assert_rd_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !we_i && addr_i == ADDR_W'(OFS_PEND))
      |=> (rdata_o[NUM_SRC-1:0] == $past(pend_i)));
   assert_rd_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !we_i && addr_i == ADDR_W'(OFS_MASK))
      |=> (rdata_o[NUM_SRC:0] == $past(mask_i)));
endmodule

// File: rtl/irq_pend_bits.sv
module irq_pend_bits #(
   parameter int NUM_SRC = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               clr_we_i,
   input  logic               tst_we_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] pend_o
);
   logic [NUM_SRC-1:0] base;

   always_comb begin
      if (tst_we_i)      base = wdata_i;
      else if (clr_we_i) base = pend_o & ~wdata_i;
      else               base = pend_o;
   end

   // a request in the same cycle overrides any clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= base | req_i;
   end

   assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_i) |=> ((pend_o & $past(req_i)) == $past(req_i)));
   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we_i && !tst_we_i) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int NUM_SRC = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_we_i,
   input  logic               mask_we_i,
   input  logic [NUM_SRC:0]   wdata_i,
   output logic [NUM_SRC-1:0] mode_o,
   output logic [NUM_SRC:0]   mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_o <= '0;
      else if (mode_we_i) mode_o <= wdata_i[NUM_SRC-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_o <= '1;
      else if (mask_we_i) mask_o <= wdata_i;
   end

   assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_route_out.sv
module irq_route_out #(
   parameter int NUM_SRC = 21,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic               gmask_i,
   input  logic [NUM_SRC-1:0] mode_i,
   output logic               fiq_o,
   output logic               irq_o
);
   logic [NUM_SRC-1:0] live;
   logic               fiq_n, irq_n;

   assign live  = pend_i & ~mask_i & {NUM_SRC{~gmask_i}};
   assign fiq_n = |(live & mode_i);
   assign irq_n = |(live & ~mode_i);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fiq_o <= 1'b0;
               irq_o <= 1'b0;
            end else begin
               fiq_o <= fiq_n;
               irq_o <= irq_n;
            end
         end

         assert_gmask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            gmask_i |=> (!fiq_o && !irq_o));
         assert_fiq_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
            fiq_o |-> $past(|(pend_i & mode_i)));
         assert_irq_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> $past(|(pend_i & ~mode_i)));
      end else begin : g_comb
         assign fiq_o = fiq_n;
         assign irq_o = irq_n;
      end
   endgenerate
endmodule

// File: rtl/irq_gate_bank.sv
module irq_gate_bank #(
   parameter int NUM_SRC  = 21,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int OFS_MODE = 'h00,
   parameter int OFS_PEND = 'h04,
   parameter int OFS_MASK = 'h08,
   parameter int OFS_TEST = 'h2C,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req_i,
   input  logic               bus_sel_i,
   input  logic               bus_we_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               fiq_o,
   output logic               irq_o,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] mask_o,
   output logic               gmask_o,
   output logic [NUM_SRC-1:0] mode_o
);
   localparam int GBIT = NUM_SRC;   // global mask sits just above the sources

   generate
      if (NUM_SRC < 1 || GBIT >= DATA_W) begin : g_bad_width
         $error("irq_gate_bank: NUM_SRC must leave room for the global bit");
      end
      if ((OFS_MODE % 4) != 0 || (OFS_PEND % 4) != 0 ||
          (OFS_MASK % 4) != 0 || (OFS_TEST % 4) != 0) begin : g_bad_ofs
         $error("irq_gate_bank: register offsets must be word aligned");
      end
      if (OFS_TEST >= (1 << ADDR_W)) begin : g_bad_addr
         $error("irq_gate_bank: offset exceeds address width");
      end
   endgenerate

   logic             mode_we, pend_we, mask_we, test_we;
   logic [GBIT:0]    mask_full;
   logic [GBIT:0]    wdata_lo;
   logic             unused_wdata_hi;

   assign wdata_lo        = bus_wdata_i[GBIT:0];
   assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:GBIT+1];

   irq_bus_port #(
      .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .OFS_MODE(OFS_MODE), .OFS_PEND(OFS_PEND),
      .OFS_MASK(OFS_MASK), .OFS_TEST(OFS_TEST)
   ) u_port (
      .clk(clk), .rst_n(rst_n),
      .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
      .mode_i(mode_o), .pend_i(pend_o), .mask_i(mask_full),
      .mode_we_o(mode_we), .pend_we_o(pend_we),
      .mask_we_o(mask_we), .test_we_o(test_we),
      .rdata_o(bus_rdata_o)
   );

   irq_pend_bits #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .req_i(src_req_i),
      .clr_we_i(pend_we), .tst_we_i(test_we),
      .wdata_i(wdata_lo[NUM_SRC-1:0]), .pend_o(pend_o)
   );

   irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .mode_we_i(mode_we), .mask_we_i(mask_we),
      .wdata_i(wdata_lo), .mode_o(mode_o), .mask_o(mask_full)
   );

   assign mask_o  = mask_full[NUM_SRC-1:0];
   assign gmask_o = mask_full[GBIT];

   irq_route_out #(.NUM_SRC(NUM_SRC), .REG_OUT(REG_OUT)) u_route (
      .clk(clk), .rst_n(rst_n),
      .pend_i(pend_o), .mask_i(mask_o), .gmask_i(gmask_o), .mode_i(mode_o),
      .fiq_o(fiq_o), .irq_o(irq_o)
   );

   assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata_o[DATA_W-1:GBIT+1] == '0);
endmodule

// File: tb/irq_gate_bank_bench.sv
`timescale 1ns/100ps
module irq_gate_bank_bench;
   localparam int N = 21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic        sel = 1'b0, we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        fiq, irq;
   logic [N-1:0] pend_x, mask_x, mode_x;
   logic        gmask_x;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_gate_bank u_irq_gate_bank (
      .clk(clk), .rst_n(rst_n), .src_req_i(req),
      .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .fiq_o(fiq), .irq_o(irq), .pend_o(pend_x), .mask_o(mask_x),
      .gmask_o(gmask_x), .mode_o(mode_x)
   );

   typedef struct {
      int          due;
      int          kind;   // 0 = read data, 1 = {fiq, irq}
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t       sb_q[$];
   int          cyc = 0;
   int          n_chk = 0, n_bad = 0;
   logic [31:0] mon_obs;
   bit          done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare every entry that falls due in this cycle
   always @(negedge clk) begin
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
         if (sb_q[i].due == cyc) begin
            mon_obs = (sb_q[i].kind == 0) ? rdata : {30'b0, fiq, irq};
            n_chk++;
            if (mon_obs !== sb_q[i].exp) begin
               n_bad++;
               $display("FAIL %s: %s got 0x%08h expected 0x%08h", sb_q[i].tag,
                        (sb_q[i].kind == 0) ? "rdata" : "fiq/irq", mon_obs, sb_q[i].exp);
            end
            sb_q.delete(i);
         end
      end
   end

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      sel = 1'b1; we = 1'b0; addr = a;
      sb_q.push_back('{due: cyc + 1, kind: 0, exp: exp, tag: tag});
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic pulse(input logic [N-1:0] r);
      req = r;
      @(negedge clk);
      req = '0;
   endtask

   // outputs follow the state changed at the last edge one edge later
   task automatic exp_out(input logic f, input logic i, input string tag);
      sb_q.push_back('{due: cyc + 1, kind: 1, exp: {30'b0, f, i}, tag: tag});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({30'b0, fiq, irq}, 32'h0, "R1 outputs in reset");
      chk(rdata, 32'h0, "R1 rdata in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk({11'b0, gmask_x, mask_x}, 32'h003F_FFFF, "R1 mask export");
      chk({11'b0, mode_x}, 32'h0, "R1 mode export");
      chk({11'b0, pend_x}, 32'h0, "R1 pend export");
      rd(8'h08, 32'h003F_FFFF, "R1 mask reset");
      rd(8'h00, 32'h0, "R1 mode reset");
      rd(8'h04, 32'h0, "R1 pend reset");

      // request latches even though everything is masked
      pulse(21'h8);
      exp_out(1'b0, 1'b0, "R5 masked source stays quiet");
      rd(8'h04, 32'h8, "R2 request sets pending");

      // write 0 keeps, write 1 clears
      wr(8'h04, 32'h0);
      rd(8'h04, 32'h8, "R3 write 0 no effect");
      wr(8'h04, 32'h8);
      rd(8'h04, 32'h0, "R3 write 1 clears");

      // enable everything, source 0 fast, the rest normal
      wr(8'h08, 32'h0);
      chk({31'b0, gmask_x}, 32'h0, "R9 global mask export");
      wr(8'h00, 32'h1);
      pulse(21'h1);
      exp_out(1'b1, 1'b0, "R4 mode 1 to fiq");
      pulse(21'h20);
      exp_out(1'b1, 1'b1, "R4 mode 0 to irq");
      @(negedge clk);

      // global mask blocks service but not latching
      wr(8'h08, 32'h0020_0000);
      exp_out(1'b0, 1'b0, "R6 global mask blocks both");
      pulse(21'h80);
      rd(8'h04, 32'h0000_00A1, "R6 pending latches under global mask");
      wr(8'h08, 32'h0);
      exp_out(1'b1, 1'b1, "R6 global unmask releases");
      @(negedge clk);

      // per-source mask on source 0
      wr(8'h08, 32'h1);
      exp_out(1'b0, 1'b1, "R5 per-source mask blocks fiq source");
      rd(8'h04, 32'h0000_00A1, "R5 pending kept while masked");

      // pending-test register
      wr(8'h2C, 32'h0);
      exp_out(1'b0, 1'b0, "R7 test write clears all");
      rd(8'h04, 32'h0, "R7 pending after test clear");
      wr(8'h2C, 32'h0010_0400);
      exp_out(1'b0, 1'b1, "R7 test write raises irq");
      chk({11'b0, pend_x}, 32'h0010_0400, "R9 pend export after test write");
      rd(8'h04, 32'h0010_0400, "R7 pending after test set");

      // request and clear on the same bit in the same cycle
      req = 21'h400;
      wr(8'h04, 32'h0010_0400);
      req = '0;
      rd(8'h04, 32'h0000_0400, "R2 request beats same-cycle clear");

      // unused bits and unmapped reads
      wr(8'h00, 32'hFFFF_FFFF);
      chk({11'b0, mode_x}, 32'h001F_FFFF, "R9 mode export all ones");
      rd(8'h00, 32'h001F_FFFF, "R8 mode upper bits read 0");
      wr(8'h2C, 32'hFFFF_FFFF);
      rd(8'h04, 32'h001F_FFFF, "R8 pending upper bits read 0");
      wr(8'h08, 32'hFFFF_FFFF);
      exp_out(1'b0, 1'b0, "R5 all masked quiet");
      rd(8'h08, 32'h003F_FFFF, "R8 mask keeps bit 21 only");
      rd(8'h2C, 32'h0, "R7 test register reads 0");
      rd(8'h10, 32'h0, "R8 unmapped offset reads 0");

      repeat (4) @(negedge clk);
      n_chk++;
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: got %0d pending items expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule